// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a segmented virtual address to a physical address. The upper bits of the virtual address pick one of sixteen segments. The lower bits give an offset, and every segment counts its offsets from zero. Each segment has a descriptor in a small on-chip table. The descriptor holds a physical base, a length and a read-only flag. Software fills the table through a single write port.

For each valid request, the block reads the descriptor of the selected segment and checks three things: that the segment is present, that the offset lies below the length, and that the access type is allowed. If all three pass, the block adds the base to the offset, so each segment covers one contiguous physical range. If any check fails, the block returns a fault code instead. The result is registered and appears one clock after the request.

Top module: `segx_top`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0, `rsp_pa` is 0 and `rsp_fault` is 0. Every descriptor reads as length 0, so any lookup returns fault code 1.
- R2: The segment number is `req_va[31:28]` and the offset is `req_va[27:0]`, read as an unsigned value starting at zero.
- R3: A lookup that passes every check returns `rsp_fault` = 0 and `rsp_pa` = base + offset, modulo 2^32.
- R4: An offset greater than or equal to a nonzero length returns fault code 2. An offset of length-1 passes.
- R5: A descriptor with length 0 is not present. Any lookup to it returns fault code 1, for reads and for writes, whatever its read-only flag.
- R6: A write lookup (`req_write`=1) to a read-only segment that is in range returns fault code 3. A read lookup to the same segment passes.
- R7: The fault codes have a fixed priority: not present (1) first, then limit (2), then protection (3).
- R8: A descriptor write on `wr_en` is used by lookups from the next cycle onward. A lookup in the same cycle as the write sees the old descriptor.
- R9: Whenever `rsp_fault` is nonzero, `rsp_pa` is 0.
- R10: `rsp_valid` equals `req_valid` of the previous cycle. When `rsp_valid` is 0, `rsp_pa` and `rsp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load a descriptor |
| wr_idx | input | 4 | Segment number of the descriptor to load |
| wr_base | input | 32 | Physical base of the segment |
| wr_len | input | 29 | Segment length in bytes; 0 marks the segment as not present |
| wr_ro | input | 1 | Read-only flag of the segment |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address (segment number, offset) |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Result is valid (one cycle after the request) |
| rsp_pa | output | 32 | Translated physical address |
| rsp_fault | output | 2 | 0 ok, 1 not present, 2 limit, 3 protection |

## Verification
Directed patterns cover the boundary cases:
- Offsets of exactly length-1 and exactly length, which separate an off-by-one limit compare from a correct one.
- A read-only segment accessed by a read and by a write.
- An out-of-range write to a read-only segment, and a write to a zero-length read-only segment, which pin down the fault priority.
- A lookup issued in the same cycle as a write to that descriptor, which separates a bypassed table from a registered one.
- A base near the top of the address space, which exposes the adder's wrap.
- A full-length segment, which exposes a truncated length field.

A long stretch of mixed pseudo-random loads and lookups then exercises all segment numbers against the reference model.

// File: rtl/segx_pkg.sv
// Package: shared widths, fault codes and descriptor layout for the
// segment translator. Assumes the segment number occupies the top bits.
package segx_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int SEG_W = 4;
    localparam int OFF_W = VA_W - SEG_W;
    localparam int LEN_W = OFF_W + 1;
    localparam int NSEG  = 1 << SEG_W;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_LIMIT  = 2'd2,
        FLT_PROT   = 2'd3
    } fault_e;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LEN_W-1:0] limit;
        logic             ro;
    } desc_t;
endpackage

// File: rtl/segx_desc_table.sv
// Descriptor table: one register per segment, loaded through one write
// port, read combinationally by segment number. Assumes a write becomes
// visible at the following clock edge, with no bypass to the read port.
module segx_desc_table
    import segx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [SEG_W-1:0] rd_idx,
    output desc_t            rd_desc
);
    desc_t tbl [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        desc_t ent_q;
        // Hold one descriptor; clear to not-present on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q <= '0;
            else if (wr_en && (wr_idx == SEG_W'(g)))
                ent_q <= wr_desc;
        end
        assign tbl[g] = ent_q;
    end

    // Select the addressed descriptor.
    always_comb rd_desc = tbl[rd_idx];

    // R8
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl[$past(wr_idx)] == $past(wr_desc));
endmodule

// File: rtl/segx_check.sv
// Access checker: decides the fault code for one lookup from the
// descriptor, offset and access type. Assumes a fixed priority of
// not-present over limit over protection.
module segx_check
    import segx_pkg::*;
(
    input  desc_t            desc,
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    output fault_e           fault
);
    logic absent, over, denied;

    // Evaluate each condition and apply the priority.
    always_comb begin
        absent = (desc.limit == '0);
        over   = ({1'b0, offset} >= desc.limit);
        denied = is_write && desc.ro;
        if (absent)      fault = FLT_ABSENT;
        else if (over)   fault = FLT_LIMIT;
        else if (denied) fault = FLT_PROT;
        else             fault = FLT_NONE;
    end
endmodule

// File: rtl/segx_addr.sv
// Address former: adds the segment base to the zero-extended offset.
// Assumes the sum wraps modulo the physical address width.
module segx_addr
    import segx_pkg::*;
(
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  pa
);
    // Form the physical address.
    always_comb pa = base + PA_W'(offset);
endmodule

// File: rtl/segx_top.sv
// Segment translator top: splits the virtual address, reads the
// descriptor, checks the access, forms the address and registers the
// result one cycle after the request. Faulted or idle results carry a
// zero address.
module segx_top
    import segx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             wr_ro,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [1:0]       rsp_fault
);
    desc_t            wdesc, rdesc;
    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [PA_W-1:0]  sum;
    fault_e           flt;

    // Split the virtual address and pack the write data.
    always_comb begin
        seg   = req_va[VA_W-1:OFF_W];
        off   = req_va[OFF_W-1:0];
        wdesc = '{base: wr_base, limit: wr_len, ro: wr_ro};
    end

    segx_desc_table u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_desc(wdesc), .rd_idx(seg), .rd_desc(rdesc)
    );

    segx_check u_chk (
        .desc(rdesc), .offset(off), .is_write(req_write), .fault(flt)
    );

    segx_addr u_add (
        .base(rdesc.base), .offset(off), .pa(sum)
    );

    // Register the response; zero address on fault or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_fault <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid ? flt : FLT_NONE;
            rsp_pa    <= (req_valid && flt == FLT_NONE) ? sum : '0;
        end
    end

    // R9
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'd0) |-> (rsp_pa == '0));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_fault == 2'd0 && rsp_pa == '0));

    // R5
    absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rdesc.limit == '0) |=> (rsp_fault == 2'd1));

    // R4
    limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rdesc.limit != '0 && {1'b0, off} >= rdesc.limit)
        |=> (rsp_fault == 2'd2));

    // R6
    prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && rdesc.ro && rdesc.limit != '0
         && {1'b0, off} < rdesc.limit) |=> (rsp_fault == 2'd3));
endmodule

// File: tb/segx_top_tb_top.sv
`timescale 1ns/1ps
module segx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_ro, req_valid, req_write;
    logic [3:0]  wr_idx;
    logic [31:0] wr_base, req_va;
    logic [28:0] wr_len;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_fault;

    always #2 clk = ~clk;

    segx_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_len(wr_len), .wr_ro(wr_ro),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
    );

    // reference model state
    logic [31:0] m_base [16];
    logic [28:0] m_len  [16];
    bit          m_ro   [16];
    bit          e_v;
    logic [31:0] e_pa;
    logic [1:0]  e_f;
    string       e_tag;
    int          n_run  = 0;
    int          n_fail = 0;

    task automatic compare();
        n_run++;
        if (rsp_valid !== e_v || rsp_pa !== e_pa || rsp_fault !== e_f) begin
            n_fail++;
            $display("FAIL %s: got v=%0d pa=%h f=%0d, expected v=%0d pa=%h f=%0d",
                     e_tag, rsp_valid, rsp_pa, rsp_fault, e_v, e_pa, e_f);
        end
    endtask

    // One cycle: check last result, drive new inputs, predict, update model.
    task automatic step(input bit we, input logic [3:0] wi, input logic [31:0] wb,
                        input logic [28:0] wl, input bit wro, input bit rv,
                        input logic [31:0] va, input bit w, input string tag);
        @(negedge clk);
        compare();
        wr_en = we; wr_idx = wi; wr_base = wb; wr_len = wl; wr_ro = wro;
        req_valid = rv; req_va = va; req_write = w;
        e_v = rv; e_pa = '0; e_f = 2'd0;
        if (!rv) e_tag = "R10";
        else begin
            int s = int'(va[31:28]);          // R2 decode
            logic [27:0] o = va[27:0];
            if (m_len[s] == 0)               begin e_f = 2'd1; e_tag = "R5,R9"; end
            else if ({1'b0, o} >= m_len[s])  begin e_f = 2'd2; e_tag = "R4,R9"; end
            else if (w && m_ro[s])           begin e_f = 2'd3; e_tag = "R6,R9"; end
            else begin e_pa = m_base[s] + {4'd0, o}; e_tag = "R2,R3"; end
        end
        if (tag != "") e_tag = tag;
        if (we) begin
            m_base[wi] = wb; m_len[wi] = wl; m_ro[wi] = wro;
        end
    endtask

    task automatic look(input logic [3:0] s, input logic [27:0] o, input bit w,
                        input string tag);
        step(0, 0, 0, 0, 0, 1, {s, o}, w, tag);
    endtask

    task automatic load(input logic [3:0] s, input logic [31:0] b,
                        input logic [28:0] l, input bit ro);
        step(1, s, b, l, ro, 0, 0, 0, "");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_len[i] = 0; m_ro[i] = 0; end
        rst_n = 0; wr_en = 0; wr_idx = 0; wr_base = 0; wr_len = 0; wr_ro = 0;
        req_valid = 0; req_va = 0; req_write = 0;
        e_v = 0; e_pa = 0; e_f = 0; e_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state, then every segment not present
        for (int s = 0; s < 16; s++) look(4'(s), 28'h10, s[0], "R1");
        // R8: write and same-cycle lookup sees old, next cycle sees new
        load(3, 32'h1000_0000, 29'h100, 0);
        step(1, 5, 32'h2000_0000, 29'h40, 0, 1, {4'd5, 28'h0}, 0, "R8");
        look(5, 28'h0, 0, "R8");
        // R4: boundary offsets
        look(3, 28'hFF, 0, "R4");
        look(3, 28'h100, 0, "R4");
        look(3, 28'h80, 1, "R3");
        // R6 and R7
        load(7, 32'h4000_0000, 29'h1000, 1);
        look(7, 28'h10, 0, "R6");
        look(7, 28'h10, 1, "R6");
        look(7, 28'h1000, 1, "R7");
        // R5 / R7: zero-length read-only segment
        load(9, 32'h5000_0000, 29'h0, 1);
        look(9, 28'h0, 1, "R7");
        load(3, 32'h1000_0000, 29'h0, 0);
        look(3, 28'h0, 0, "R5");
        // R3: wrap of the sum
        load(10, 32'hFFFF_FF00, 29'h1000, 0);
        look(10, 28'h200, 0, "R3");
        // R4: full-length segment
        load(15, 32'h8000_0000, 29'h1000_0000, 0);
        look(15, 28'hFFF_FFFF, 1, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // mixed pseudo-random traffic
        for (int k = 0; k < 4000; k++) begin
            bit we = ($urandom % 4) == 0;
            logic [28:0] l = (($urandom % 5) == 0) ? 29'd0 : 29'($urandom % 8192);
            logic [27:0] o = 28'($urandom % 9000);
            step(we, 4'($urandom), $urandom, l, 1'($urandom),
                 ($urandom % 5) != 0, {4'($urandom), o}, 1'($urandom), "");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "");
        @(negedge clk);
        compare();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule